// File: doc/BRIEF.md
# NAND Flash Host Register Interface

This block is a small register window through which a processor operates a raw NAND flash device by hand. Software sets the command-latch, address-latch, chip-enable and write-protect pins through a control register. It moves bytes through a data port that produces the write and read strobe pulses itself. The ready/busy pin of the device can be seen in the control register.

Every byte that crosses the data port, in either direction, also passes through a Hamming ECC accumulator. The accumulator builds two line-parity bytes, a six-bit column parity and a byte counter over a 256-byte page. Software reads the parity back, with the two line-parity bytes bit-interleaved across two registers, and clears it with a write to a dedicated offset. A 32-bit read of the data port fetches two bytes from the device in one bus access.

Each bus access is started by a one-cycle `bus_rd` or `bus_wr` strobe while the block is idle and ends with a one-cycle `bus_done` pulse. Strobes that arrive before that pulse are ignored. When both strobes are high in the same cycle, the write is taken.

Top module: `nand_host_regs`

## Requirements
- R1: After reset the control register is zero, so `nand_ce_n`, `nand_cle`, `nand_ale` and `nand_wp` are low. `nand_we_n` and `nand_re_n` are high, `nand_io_oe` is low, and the counter and all parity state are zero.
- R2: A write to offset 0x18 stores the byte with bit 5 forced to zero. The pins follow the stored value from the next cycle: `nand_cle` is bit 1, `nand_ale` is bit 2, `nand_wp` is bit 3, and `nand_ce_n` is the OR of bit 0 and bit 4. The pins change on no other access.
- R3: A read of offset 0x18 returns the stored control byte with bit 5 replaced by the level of `nand_rb` sampled in the issue cycle.
- R4: A write to offset 0x14 drives `bus_wdata` on `nand_io_out` with `nand_io_oe` high. `nand_we_n` goes low for exactly one cycle, and the data stays driven for one further cycle. `nand_we_n` and `nand_re_n` are never low together.
- R5: A byte read of offset 0x14 (`bus_word` low) gives one single-cycle `nand_re_n` pulse. It returns the `nand_io_in` value sampled at the end of that pulse in `bus_rdata[7:0]`, with every other bit zero.
- R6: A word read of offset 0x14 (`bus_word` high) gives two single-cycle `nand_re_n` pulses separated by one high cycle. It returns the first byte in `bus_rdata[7:0]`, the second in `bus_rdata[23:16]` and zero elsewhere.
- R7: Every byte written to or read from the data port updates the ECC state, and the counter grows by one per byte. Let idx be the low 8 bits of the counter before the update. A byte with an odd number of ones XORs idx into line parity P0 and ~idx into line parity P1. For j = 0..2, column parity bit 2j+1 XOR-accumulates the data bits whose position has bit j set, and bit 2j accumulates those whose position has bit j clear.
- R8: Reading offset 0x00 returns P0[7:4] in result bits 0,2,4,6 and P1[7:4] in bits 1,3,5,7. Reading offset 0x04 returns P0[3:0] in bits 0,2,4,6 and P1[3:0] in bits 1,3,5,7.
- R9: Offset 0x08 reads the column parity in bits 5:0. Offset 0x0C reads the low 8 bits of the byte counter.
- R10: Any write to offset 0x10, whatever its data, sets the counter and all parity state to zero from the next cycle.
- R11: Reads of offsets with no register (including 0x10) return zero. Writes to such offsets, and to 0x00 to 0x0C, change no state and produce no NAND strobe.
- R12: `bus_done` is a single-cycle pulse ending every access. For register (non-data-port) accesses it comes in the cycle right after the issue cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_word | input | 1 | Selects a two-byte read of the data port |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_done |
| bus_done | output | 1 | Access complete pulse |
| nand_io_out | output | 8 | Data driven toward the flash |
| nand_io_oe | output | 1 | Output enable for nand_io_out |
| nand_io_in | input | 8 | Data from the flash |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_wp | output | 1 | Write protect level |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_rb | input | 1 | Ready (high) / busy (low) from the flash |

## Verification
The bench builds the block with ADDR_W = 5 and CNT_W = 10. A 10-bit counter wraps on its own at 1024, while the readable count and the line-parity index still wrap at 256. A run of 300 bytes therefore crosses the page-index wrap. The random stream mixes data-port writes, byte and word reads, control writes with random ready levels and parity readbacks, so the interleaved line-parity layout gets checked against many parity states.

// File: rtl/nand_host_regs.sv
module nand_host_regs #(
  parameter int ADDR_W = 5,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic              bus_word,
  input  logic [7:0]        bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_done,
  output logic [7:0]        nand_io_out,
  output logic              nand_io_oe,
  input  logic [7:0]        nand_io_in,
  output logic              nand_cle,
  output logic              nand_ale,
  output logic              nand_ce_n,
  output logic              nand_wp,
  output logic              nand_we_n,
  output logic              nand_re_n,
  input  logic              nand_rb
);

  localparam logic [ADDR_W-1:0] OFF_LPA = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] OFF_LPB = ADDR_W'(8'h04);
  localparam logic [ADDR_W-1:0] OFF_CP  = ADDR_W'(8'h08);
  localparam logic [ADDR_W-1:0] OFF_CNT = ADDR_W'(8'h0C);
  localparam logic [ADDR_W-1:0] OFF_CLR = ADDR_W'(8'h10);
  localparam logic [ADDR_W-1:0] OFF_IO  = ADDR_W'(8'h14);
  localparam logic [ADDR_W-1:0] OFF_CTL = ADDR_W'(8'h18);

  typedef enum logic [2:0] {S_IDLE, S_RD1, S_RGAP, S_RD2, S_WR1, S_WH} state_t;

  state_t           st;
  logic [7:0]       ctl;
  logic [7:0]       byte0;
  logic             word_q;
  logic [7:0]       lp0, lp1;
  logic [5:0]       cp;
  logic [CNT_W-1:0] ecc_cnt;

  wire idle    = (st == S_IDLE);
  wire a_io    = (bus_addr == OFF_IO);
  wire a_ctl   = (bus_addr == OFF_CTL);
  wire a_clr   = (bus_addr == OFF_CLR);
  wire ctl_wr  = idle && bus_wr && a_ctl;
  wire ecc_clr = idle && bus_wr && a_clr;
  wire dig_en  = (idle && bus_wr && a_io) || (st == S_RD1) || (st == S_RD2);
  wire [7:0] dig_byte = idle ? bus_wdata : nand_io_in;

  assign nand_cle  = ctl[1];
  assign nand_ale  = ctl[2];
  assign nand_wp   = ctl[3];
  assign nand_ce_n = ctl[0] | ctl[4];

  // column contribution of one byte
  logic [5:0] col_c;
  always_comb begin
    col_c = '0;
    for (int j = 0; j < 3; j++)
      for (int b = 0; b < 8; b++)
        if (((b >> j) & 1) == 1) col_c[2*j+1] = col_c[2*j+1] ^ dig_byte[b];
        else                     col_c[2*j]   = col_c[2*j]   ^ dig_byte[b];
  end

  wire [7:0] idx = ecc_cnt[7:0];

  always_ff @(posedge clk) begin
    if (!rst_n || ecc_clr) begin
      lp0 <= '0; lp1 <= '0; cp <= '0; ecc_cnt <= '0;
    end else if (dig_en) begin
      if (^dig_byte) begin
        lp0 <= lp0 ^ idx;
        lp1 <= lp1 ^ ~idx;
      end
      cp      <= cp ^ col_c;
      ecc_cnt <= ecc_cnt + 1'b1;
    end
  end

  logic [7:0] reg_val;
  always_comb begin
    reg_val = '0;
    case (bus_addr)
      OFF_LPA: for (int i = 0; i < 4; i++) begin
                 reg_val[2*i]   = lp0[4+i];
                 reg_val[2*i+1] = lp1[4+i];
               end
      OFF_LPB: for (int i = 0; i < 4; i++) begin
                 reg_val[2*i]   = lp0[i];
                 reg_val[2*i+1] = lp1[i];
               end
      OFF_CP:  reg_val = {2'b00, cp};
      OFF_CNT: reg_val = ecc_cnt[7:0];
      OFF_CTL: reg_val = ctl | {2'b00, nand_rb, 5'b0};
      default: reg_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; ctl <= '0; byte0 <= '0; word_q <= 1'b0;
      nand_we_n <= 1'b1; nand_re_n <= 1'b1; nand_io_oe <= 1'b0;
      nand_io_out <= '0; bus_rdata <= '0; bus_done <= 1'b0;
    end else begin
      bus_done <= 1'b0;
      case (st)
        S_IDLE:
          if (bus_wr) begin
            if (a_io) begin
              nand_io_out <= bus_wdata;
              nand_io_oe  <= 1'b1;
              nand_we_n   <= 1'b0;
              st          <= S_WR1;
            end else begin
              if (a_ctl) ctl <= bus_wdata & 8'hDF;
              bus_done <= 1'b1;
            end
          end else if (bus_rd) begin
            if (a_io) begin
              nand_re_n <= 1'b0;
              word_q    <= bus_word;
              st        <= S_RD1;
            end else begin
              bus_rdata <= {24'b0, reg_val};
              bus_done  <= 1'b1;
            end
          end
        S_WR1: begin nand_we_n <= 1'b1; st <= S_WH; end
        S_WH:  begin nand_io_oe <= 1'b0; bus_done <= 1'b1; st <= S_IDLE; end
        S_RD1: begin
          nand_re_n <= 1'b1;
          byte0     <= nand_io_in;
          if (word_q) st <= S_RGAP;
          else begin
            bus_rdata <= {24'b0, nand_io_in};
            bus_done  <= 1'b1;
            st        <= S_IDLE;
          end
        end
        S_RGAP: begin nand_re_n <= 1'b0; st <= S_RD2; end
        S_RD2: begin
          nand_re_n <= 1'b1;
          bus_rdata <= {8'b0, nand_io_in, 8'b0, byte0};
          bus_done  <= 1'b1;
          st        <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_pins_follow_ctl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({nand_cle, nand_ale, nand_wp, nand_ce_n}) |-> $past(ctl_wr));
  assert_strobes_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(!nand_we_n && !nand_re_n));
  assert_we_data_driven_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !nand_we_n |-> nand_io_oe);
  assert_we_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !nand_we_n |=> nand_we_n && nand_io_oe);
  assert_re_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !nand_re_n |=> nand_re_n);
  assert_cnt_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ecc_cnt) |-> ($past(ecc_clr) || ecc_cnt == CNT_W'($past(ecc_cnt) + 1'b1)));
  assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ecc_clr |=> (ecc_cnt == '0 && lp0 == '0 && lp1 == '0 && cp == '0));
  assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    bus_done |=> !bus_done);

endmodule

// File: tb/nand_host_regs_test.sv
module nand_host_regs_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [4:0]  bus_addr = '0;
  logic        bus_rd = 0, bus_wr = 0, bus_word = 0;
  logic [7:0]  bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_done;
  logic [7:0]  nand_io_out, nand_io_in;
  logic        nand_io_oe, nand_cle, nand_ale, nand_ce_n, nand_wp, nand_we_n, nand_re_n;
  logic        nand_rb = 1'b1;

  nand_host_regs #(.ADDR_W(5), .CNT_W(10)) uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_word(bus_word), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_done(bus_done),
    .nand_io_out(nand_io_out), .nand_io_oe(nand_io_oe), .nand_io_in(nand_io_in),
    .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_ce_n(nand_ce_n), .nand_wp(nand_wp),
    .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_rb(nand_rb));

  logic [7:0] rd_src [0:3];
  int rd_idx = 0;
  assign nand_io_in = rd_src[rd_idx[1:0]];
  always @(posedge nand_re_n) if (rst_n) rd_idx <= rd_idx + 1;

  int re_pulses = 0, we_pulses = 0;
  logic [7:0] we_data;
  logic       we_oe;
  always @(negedge nand_re_n) if (rst_n) re_pulses++;
  always @(posedge nand_we_n) if (rst_n) begin
    we_pulses++; we_data = nand_io_out; we_oe = nand_io_oe;
  end

  int total = 0, bad = 0, lat = 0;
  bit finished = 0;

  logic [7:0] m_lp0 = 0, m_lp1 = 0, m_ctl = 0;
  logic [5:0] m_cp = 0;
  int m_cnt = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic void mdig(input logic [7:0] d);
    logic [7:0] ix = 8'(m_cnt % 256);
    if (^d) begin m_lp0 ^= ix; m_lp1 ^= ~ix; end
    m_cp ^= {^(d & 8'hF0), ^(d & 8'h0F), ^(d & 8'hCC), ^(d & 8'h33), ^(d & 8'hAA), ^(d & 8'h55)};
    m_cnt++;
  endfunction

  function automatic logic [7:0] exp_lp(input bit hi);
    logic [7:0] r;
    for (int i = 0; i < 4; i++) begin
      r[2*i]   = hi ? m_lp0[4+i] : m_lp0[i];
      r[2*i+1] = hi ? m_lp1[4+i] : m_lp1[i];
    end
    return r;
  endfunction

  task automatic access(input bit wr, input logic [4:0] a, input bit word,
                        input logic [7:0] d, output logic [31:0] q);
    int n = 0;
    @(negedge clk);
    bus_addr = a; bus_wr = wr; bus_rd = !wr; bus_word = word; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0; bus_rd = 0; bus_word = 0;
    while (!bus_done && n < 20) begin @(negedge clk); n++; end
    lat = n;
    q = bus_rdata;
    if (!bus_done) chk(0, "R12 done missing", 0, 1);
  endtask

  task automatic wr_io(input logic [7:0] d);
    logic [31:0] q;
    int wp0 = we_pulses;
    access(1, 5'h14, 0, d, q);
    mdig(d);
    chk(we_pulses == wp0 + 1 && we_data == d && we_oe, "R4 data write", {we_oe, we_data}, {1'b1, d});
  endtask

  task automatic rd_io(input bit word);
    logic [31:0] q;
    logic [7:0] b0 = 8'($urandom), b1 = 8'($urandom);
    int rp0 = re_pulses;
    rd_src[0] = b0; rd_src[1] = b1; rd_idx = 0;
    access(0, 5'h14, word, 0, q);
    mdig(b0);
    if (word) begin
      mdig(b1);
      chk(q == {8'h0, b1, 8'h0, b0} && re_pulses == rp0 + 2, "R6 word read", q, {8'h0, b1, 8'h0, b0});
    end else
      chk(q == {24'h0, b0} && re_pulses == rp0 + 1, "R5 byte read", q, {24'h0, b0});
  endtask

  task automatic rd_reg(input logic [4:0] a, input logic [7:0] exp, input string req);
    logic [31:0] q;
    access(0, a, 0, 0, q);
    chk(q == {24'h0, exp}, req, q, {24'h0, exp});
    chk(lat == 0, "R12 register latency", lat, 0);
  endtask

  task automatic check_ecc();
    rd_reg(5'h00, exp_lp(1), "R8 line parity A");
    rd_reg(5'h04, exp_lp(0), "R8 line parity B");
    rd_reg(5'h08, {2'b0, m_cp}, "R9 column parity");
    rd_reg(5'h0C, 8'(m_cnt % 256), "R9 counter");
  endtask

  task automatic wr_ctl(input logic [7:0] d);
    logic [31:0] q;
    access(1, 5'h18, 0, d, q);
    m_ctl = d & 8'hDF;
    chk({nand_ce_n, nand_wp, nand_ale, nand_cle} == {d[0] | d[4], d[3], d[2], d[1]},
        "R2 control pins", {nand_ce_n, nand_wp, nand_ale, nand_cle}, {d[0] | d[4], d[3], d[2], d[1]});
  endtask

  initial begin
    logic [31:0] q;
    int unsigned seed;
    logic [3:0] pins;
    int wp0;
    seed = $urandom(32'h1234);
    rd_src[0] = 0; rd_src[1] = 0; rd_src[2] = 0; rd_src[3] = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk({nand_ce_n, nand_cle, nand_ale, nand_wp, nand_we_n, nand_re_n, nand_io_oe} == 7'b0000110,
        "R1 reset pins", {nand_ce_n, nand_cle, nand_ale, nand_wp, nand_we_n, nand_re_n, nand_io_oe}, 7'b0000110);
    nand_rb = 1;
    rd_reg(5'h18, 8'h20, "R1 R3 control after reset");
    check_ecc();

    // R7 known single byte: 0x01 at index 0 -> P1=FF, col=0x15
    wr_io(8'h01);
    rd_reg(5'h00, 8'hAA, "R7 R8 known line parity A");
    rd_reg(5'h04, 8'hAA, "R7 R8 known line parity B");
    rd_reg(5'h08, 8'h15, "R7 known column parity");

    // R2 bit 5 masked on write, R3 live ready
    wr_ctl(8'hFF);
    nand_rb = 0;
    rd_reg(5'h18, 8'hDF, "R2 R3 control busy");
    nand_rb = 1;
    rd_reg(5'h18, 8'hFF, "R3 control ready");
    wr_ctl(8'h00);

    // random mix
    for (int it = 0; it < 600; it++) begin
      case ($urandom % 6)
        0: wr_io(8'($urandom));
        1: rd_io(0);
        2: rd_io(1);
        3: wr_ctl(8'($urandom));
        4: begin
          nand_rb = 1'($urandom);
          rd_reg(5'h18, m_ctl | {2'b0, nand_rb, 5'b0}, "R3 control read");
        end
        default: check_ecc();
      endcase
    end
    check_ecc();

    // R10 clear with arbitrary data
    access(1, 5'h10, 0, 8'hA5, q);
    m_lp0 = 0; m_lp1 = 0; m_cp = 0; m_cnt = 0;
    check_ecc();

    // R7 index wrap beyond 256 bytes
    for (int i = 0; i < 300; i++) wr_io(8'($urandom));
    check_ecc();

    // R11 undefined and read-only offsets
    rd_reg(5'h1C, 8'h00, "R11 undefined read");
    rd_reg(5'h10, 8'h00, "R11 clear reads zero");
    rd_reg(5'h01, 8'h00, "R11 misaligned read");
    pins = {nand_ce_n, nand_wp, nand_ale, nand_cle};
    wp0 = we_pulses;
    access(1, 5'h00, 0, 8'h5A, q);
    access(1, 5'h0C, 0, 8'h33, q);
    access(1, 5'h1C, 0, 8'hFF, q);
    chk(we_pulses == wp0 && {nand_ce_n, nand_wp, nand_ale, nand_cle} == pins, "R11 ignored writes",
        {we_pulses, pins}, {wp0, pins});
    check_ecc();
    rd_reg(5'h18, m_ctl | {2'b0, nand_rb, 5'b0}, "R11 control unchanged");

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2000000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule